// File: doc/BRIEF.md
# Low-Power Lane Request Decoder

This block sits on the receive side of one serial display lane. Its input is the pair of single-ended low-power line levels, positive wire and negative wire, already sampled into the local clock. It tracks the multi-step level sequences that a transmitter drives to take the lane out of its idle (stop) level, which is both wires high. It reports the mode the lane is in and emits one-cycle pulses when a request completes or a sequence breaks.

Each level must stay steady for a set number of samples before the decoder accepts it, so short glitches are filtered out. After reset the lane stays in an initialization mode until the idle level has been held for a set time. A parameter selects a data-lane variant or a clock-lane variant. The data lane decodes high-speed, escape and turnaround requests. The clock lane decodes high-speed requests and ultra-low-power entry, and it enforces a minimum wake-up time on ultra-low-power exit. Logic downstream uses the mode code to enable the high-speed receiver, the escape command decoder or the line drivers for turnaround.

Top module: `lane_lp_decoder`

## Requirements
- R1: While reset is asserted and just after it, `mode_o` reads 0 (init) and every pulse output is low. The mode codes are: 0 init, 1 stop, 2 high-speed, 3 escape, 4 turnaround, 5 ultra-low-power.
- R2: Mode moves from init to stop only after the accepted level {line_p,line_n}=11 has been held for INIT_CYC cycles. Any other held level keeps the mode at init.
- R3: A new line level is accepted only after it is sampled unchanged on STABLE+1 consecutive clock edges. A shorter excursion changes no output.
- R4: From stop, accepted levels 01 then 00 give one `hs_req_o` pulse and mode 2. Mode 2 returns to stop only when 11 is accepted, and other levels are ignored.
- R5: On a data lane, 10, 00, 01, 00 from stop give one `esc_req_o` pulse and mode 3. Escape is left to stop by 10 followed by 11, with no error.
- R6: On a data lane, 10, 00, 10, 00 from stop give one `turn_req_o` pulse and mode 4. Mode 4 returns to stop when 11 is accepted.
- R7: An accepted level that does not fit the next step of a sequence gives a one-cycle `seq_err_o` pulse. If that level is 11 the lane goes to stop. Otherwise no request is decoded until 11 is accepted.
- R8: In escape mode, 11 accepted right after any level other than 10 gives a `seq_err_o` pulse and the lane goes to stop.
- R9: On a clock lane (IS_CLK_LANE=1), 10 then 00 from stop give one `ulp_req_o` pulse and mode 5. A data lane never pulses `ulp_req_o`.
- R10: Ultra-low-power exit requires 10 accepted and held at least WAKE_CYC cycles before 11 is accepted. It then goes to stop with no error. If 11 is accepted earlier, the lane raises `seq_err_o` and goes to stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_p | input | 1 | Sampled low-power level of the positive wire |
| line_n | input | 1 | Sampled low-power level of the negative wire |
| mode_o | output | 3 | Current lane mode code (see R1) |
| hs_req_o | output | 1 | One-cycle pulse: high-speed request decoded |
| esc_req_o | output | 1 | One-cycle pulse: escape request decoded |
| turn_req_o | output | 1 | One-cycle pulse: turnaround request decoded |
| ulp_req_o | output | 1 | One-cycle pulse: ultra-low-power entry decoded |
| seq_err_o | output | 1 | One-cycle pulse: sequence violation |

## Verification
The escape and turnaround sequences share their first two steps. The bench drives both, so a decoder that confuses the third step would report the wrong request or mode. A two-cycle glitch is sent in the stop state: a filter that is too short would start a high-speed sequence and later raise a spurious error. After an error the bench replays a valid tail without passing through idle, which a decoder that forgets to wait for 11 would turn into a request. On the clock lane, ultra-low-power exit is tried both after a long and after a short wake-up hold, which catches a missing or inverted wake timer. An escape exit that skips the 10 step must raise an error.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
   typedef enum logic [2:0] {
      MODE_INIT = 3'd0,
      MODE_STOP = 3'd1,
      MODE_HS   = 3'd2,
      MODE_ESC  = 3'd3,
      MODE_TURN = 3'd4,
      MODE_ULP  = 3'd5
   } lane_mode_e;

   localparam logic [1:0] LVL_00 = 2'b00;
   localparam logic [1:0] LVL_01 = 2'b01;
   localparam logic [1:0] LVL_10 = 2'b10;
   localparam logic [1:0] LVL_11 = 2'b11;
endpackage

// File: rtl/lpd_glitch_filter.sv
module lpd_glitch_filter #(
   parameter int STABLE = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] raw_i,
   output logic [1:0] lvl_o,
   output logic       chg_o
);
   localparam int CW = (STABLE < 2) ? 1 : $clog2(STABLE + 1);
   localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

   logic [1:0]    cand_q, acc_q;
   logic [CW-1:0] run_q;
   logic          chg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand_q <= 2'b00;
         acc_q  <= 2'b00;
         run_q  <= '0;
         chg_q  <= 1'b0;
      end else begin
         chg_q <= 1'b0;
         if (raw_i != cand_q) begin
            cand_q <= raw_i;
            run_q  <= '0;
         end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
         end else if (acc_q != cand_q) begin
            acc_q <= cand_q;
            chg_q <= 1'b1;
         end
      end
   end

   assign lvl_o = acc_q;
   assign chg_o = chg_q;

   // R3: an accepted level was present on the raw input at the accepting edge
   p_accept_held_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q != $past(acc_q)) |-> (acc_q == $past(raw_i) && acc_q == $past(cand_q)));
endmodule

// File: rtl/lpd_seq_fsm.sv
module lpd_seq_fsm
   import lpd_pkg::*;
#(
   parameter bit IS_CLK_LANE = 1'b0,
   parameter int INIT_CYC    = 2000,
   parameter int WAKE_CYC    = 20000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] lvl_i,
   input  logic       chg_i,
   output lane_mode_e mode_o,
   output logic       hs_o,
   output logic       esc_o,
   output logic       bta_o,
   output logic       ulp_o,
   output logic       err_o
);
   localparam int CNT_MAX = (INIT_CYC > WAKE_CYC) ? INIT_CYC : WAKE_CYC;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);
   localparam logic [CW-1:0] WAKE_MIN  = CW'(WAKE_CYC);
   localparam logic [CW-1:0] SAT       = CW'(CNT_MAX);

   typedef enum logic [3:0] {
      ST_INIT, ST_STOP, ST_H1, ST_E1, ST_E2, ST_E3, ST_T3,
      ST_HS, ST_ESC, ST_TA, ST_ULP, ST_WAKE, ST_WAIT
   } seq_st_e;

   seq_st_e       st_q, st_n;
   logic [1:0]    prev_q;
   logic [CW-1:0] cnt_q;
   logic          hs_n, esc_n, bta_n, ulp_n, err_n;
   logic          e1_to_ulp;
   lane_mode_e    mode_q, mode_n;

   generate
      if (IS_CLK_LANE) begin : g_clk_lane
         assign e1_to_ulp = 1'b1;
      end else begin : g_data_lane
         assign e1_to_ulp = 1'b0;
      end
   endgenerate

   always_comb begin
      st_n  = st_q;
      hs_n  = 1'b0;
      esc_n = 1'b0;
      bta_n = 1'b0;
      ulp_n = 1'b0;
      err_n = 1'b0;
      case (st_q)
         ST_INIT: if (lvl_i == LVL_11 && cnt_q >= INIT_LAST) st_n = ST_STOP;
         ST_STOP: if (chg_i) begin
            if (lvl_i == LVL_01)      st_n = ST_H1;
            else if (lvl_i == LVL_10) st_n = ST_E1;
            else begin err_n = 1'b1; st_n = ST_WAIT; end
         end
         ST_H1: if (chg_i) begin
            if (lvl_i == LVL_00) begin st_n = ST_HS; hs_n = 1'b1; end
            else begin err_n = 1'b1; st_n = (lvl_i == LVL_11) ? ST_STOP : ST_WAIT; end
         end
         ST_E1: if (chg_i) begin
            if (lvl_i == LVL_00) begin
               if (e1_to_ulp) begin st_n = ST_ULP; ulp_n = 1'b1; end
               else st_n = ST_E2;
            end else begin err_n = 1'b1; st_n = (lvl_i == LVL_11) ? ST_STOP : ST_WAIT; end
         end
         ST_E2: if (chg_i) begin
            if (lvl_i == LVL_01)      st_n = ST_E3;
            else if (lvl_i == LVL_10) st_n = ST_T3;
            else begin err_n = 1'b1; st_n = (lvl_i == LVL_11) ? ST_STOP : ST_WAIT; end
         end
         ST_E3: if (chg_i) begin
            if (lvl_i == LVL_00) begin st_n = ST_ESC; esc_n = 1'b1; end
            else begin err_n = 1'b1; st_n = (lvl_i == LVL_11) ? ST_STOP : ST_WAIT; end
         end
         ST_T3: if (chg_i) begin
            if (lvl_i == LVL_00) begin st_n = ST_TA; bta_n = 1'b1; end
            else begin err_n = 1'b1; st_n = (lvl_i == LVL_11) ? ST_STOP : ST_WAIT; end
         end
         ST_HS, ST_TA, ST_WAIT: if (chg_i && lvl_i == LVL_11) st_n = ST_STOP;
         ST_ESC: if (chg_i && lvl_i == LVL_11) begin
            st_n  = ST_STOP;
            err_n = (prev_q != LVL_10);
         end
         ST_ULP: if (chg_i) begin
            if (lvl_i == LVL_10) st_n = ST_WAKE;
            else if (lvl_i == LVL_11) begin err_n = 1'b1; st_n = ST_STOP; end
         end
         ST_WAKE: if (chg_i) begin
            if (lvl_i == LVL_11) begin
               st_n  = ST_STOP;
               err_n = (cnt_q < WAKE_MIN);
            end else if (lvl_i == LVL_00) st_n = ST_ULP;
         end
         default: st_n = ST_WAIT;
      endcase
   end

   always_comb begin
      case (st_n)
         ST_INIT:         mode_n = MODE_INIT;
         ST_HS:           mode_n = MODE_HS;
         ST_ESC:          mode_n = MODE_ESC;
         ST_TA:           mode_n = MODE_TURN;
         ST_ULP, ST_WAKE: mode_n = MODE_ULP;
         default:         mode_n = MODE_STOP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_INIT;
         mode_q <= MODE_INIT;
         prev_q <= LVL_00;
         cnt_q  <= '0;
         hs_o   <= 1'b0;
         esc_o  <= 1'b0;
         bta_o  <= 1'b0;
         ulp_o  <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         st_q   <= st_n;
         mode_q <= mode_n;
         prev_q <= lvl_i;
         hs_o   <= hs_n;
         esc_o  <= esc_n;
         bta_o  <= bta_n;
         ulp_o  <= ulp_n;
         err_o  <= err_n;
         if ((st_q == ST_INIT && lvl_i == LVL_11) || st_q == ST_WAKE)
            cnt_q <= (cnt_q == SAT) ? cnt_q : cnt_q + 1'b1;
         else
            cnt_q <= '0;
      end
   end

   assign mode_o = mode_q;

   // R2: init is left only towards stop
   p_init_to_stop_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_q) == MODE_INIT && mode_q != MODE_INIT) |-> mode_q == MODE_STOP);
   // R4: high-speed mode ends only after idle level was accepted
   p_hs_exit_idle_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_q) == MODE_HS && mode_q != MODE_HS) |-> $past(lvl_i) == LVL_11);
   // R7: error pulses last one cycle
   p_err_single_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);
   // R9: at most one request pulse per cycle, ULP only on a clock lane
   p_req_onehot_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hs_o, esc_o, bta_o, ulp_o}) && (IS_CLK_LANE || !ulp_o));
endmodule

// File: rtl/lane_lp_decoder.sv
module lane_lp_decoder
   import lpd_pkg::*;
#(
   parameter bit IS_CLK_LANE = 1'b0,
   parameter int STABLE      = 3,
   parameter int INIT_CYC    = 2000,
   parameter int WAKE_CYC    = 20000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_p,
   input  logic       line_n,
   output logic [2:0] mode_o,
   output logic       hs_req_o,
   output logic       esc_req_o,
   output logic       turn_req_o,
   output logic       ulp_req_o,
   output logic       seq_err_o
);
   generate
      if (STABLE < 1) begin : g_bad_stable
         $error("STABLE must be at least 1");
      end
      if (INIT_CYC < 1 || WAKE_CYC < 1) begin : g_bad_timer
         $error("INIT_CYC and WAKE_CYC must be at least 1");
      end
   endgenerate

   logic [1:0] lvl;
   logic       chg;
   lane_mode_e mode;

   lpd_glitch_filter #(.STABLE(STABLE)) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i ({line_p, line_n}),
      .lvl_o (lvl),
      .chg_o (chg)
   );

   lpd_seq_fsm #(
      .IS_CLK_LANE (IS_CLK_LANE),
      .INIT_CYC    (INIT_CYC),
      .WAKE_CYC    (WAKE_CYC)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .chg_i  (chg),
      .mode_o (mode),
      .hs_o   (hs_req_o),
      .esc_o  (esc_req_o),
      .bta_o  (turn_req_o),
      .ulp_o  (ulp_req_o),
      .err_o  (seq_err_o)
   );

   assign mode_o = mode;
endmodule

// File: tb/lane_lp_decoder_bench.sv
module lane_lp_decoder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int STABLE = 3;
   localparam int INIT_CYC = 20;
   localparam int WAKE_CYC = 30;
   localparam int HOLD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_p = 1'b1, line_n = 1'b1;
   logic [2:0] d_mode, c_mode;
   logic d_hs, d_esc, d_bta, d_ulp, d_err;
   logic c_hs, c_esc, c_bta, c_ulp, c_err;
   int n_chk = 0, n_bad = 0;
   int k_hs = 0, k_esc = 0, k_bta = 0, k_dulp = 0, k_derr = 0, k_culp = 0, k_cerr = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_lp_decoder #(.IS_CLK_LANE(1'b0), .STABLE(STABLE), .INIT_CYC(INIT_CYC),
                     .WAKE_CYC(WAKE_CYC)) u_lane_lp_decoder (
      .clk(clk), .rst_n(rst_n), .line_p(line_p), .line_n(line_n), .mode_o(d_mode),
      .hs_req_o(d_hs), .esc_req_o(d_esc), .turn_req_o(d_bta), .ulp_req_o(d_ulp),
      .seq_err_o(d_err));

   lane_lp_decoder #(.IS_CLK_LANE(1'b1), .STABLE(STABLE), .INIT_CYC(INIT_CYC),
                     .WAKE_CYC(WAKE_CYC)) u_lane_lp_decoder_ck (
      .clk(clk), .rst_n(rst_n), .line_p(line_p), .line_n(line_n), .mode_o(c_mode),
      .hs_req_o(c_hs), .esc_req_o(c_esc), .turn_req_o(c_bta), .ulp_req_o(c_ulp),
      .seq_err_o(c_err));

   always @(negedge clk) if (rst_n) begin
      k_hs += d_hs; k_esc += d_esc; k_bta += d_bta; k_dulp += d_ulp; k_derr += d_err;
      k_culp += c_ulp; k_cerr += c_err;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] lvl, input int cyc = HOLD);
      @(negedge clk);
      {line_p, line_n} = lvl;
      repeat (cyc) @(negedge clk);
   endtask

   task automatic restart();
      @(negedge clk);
      rst_n = 1'b0;
      {line_p, line_n} = 2'b11;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2 * INIT_CYC) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      {line_p, line_n} = 2'b11;
      repeat (3) @(negedge clk);
      check("R1 mode in reset", d_mode, 0);
      check("R1 pulses in reset", {d_hs, d_esc, d_bta, d_ulp, d_err}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R2 still init early", d_mode, 0);
      repeat (2 * INIT_CYC) @(negedge clk);
      check("R2 stop after idle hold", d_mode, 1);
      @(negedge clk);
      rst_n = 1'b0;
      {line_p, line_n} = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4 * INIT_CYC) @(negedge clk);
      check("R2 init kept without idle", d_mode, 0);
   endtask

   task automatic t_hs();
      int b_hs, b_err;
      restart();
      b_hs = k_hs; b_err = k_derr;
      drive(2'b01); drive(2'b00);
      check("R4 hs pulse", k_hs - b_hs, 1);
      check("R4 hs mode", d_mode, 2);
      drive(2'b01); drive(2'b00);
      check("R4 hs ignores non-idle", d_mode, 2);
      drive(2'b11);
      check("R4 hs exit", d_mode, 1);
      check("R4 no error", k_derr - b_err, 0);
   endtask

   task automatic t_glitch();
      int b_hs, b_err;
      restart();
      b_hs = k_hs; b_err = k_derr;
      drive(2'b01, 2); drive(2'b11);
      drive(2'b00, 2); drive(2'b11);
      check("R3 glitch no error", k_derr - b_err, 0);
      check("R3 glitch mode", d_mode, 1);
      drive(2'b01, STABLE + 2); drive(2'b00);
      check("R3 held level accepted", k_hs - b_hs, 1);
   endtask

   task automatic t_esc();
      int b_esc, b_err;
      restart();
      b_esc = k_esc; b_err = k_derr;
      drive(2'b10); drive(2'b00); drive(2'b01); drive(2'b00);
      check("R5 esc pulse", k_esc - b_esc, 1);
      check("R5 esc mode", d_mode, 3);
      drive(2'b10); drive(2'b11);
      check("R5 esc exit mode", d_mode, 1);
      check("R5 esc exit clean", k_derr - b_err, 0);
      drive(2'b10); drive(2'b00); drive(2'b01); drive(2'b00);
      drive(2'b11);
      check("R8 bad esc exit error", k_derr - b_err, 1);
      check("R8 bad esc exit mode", d_mode, 1);
   endtask

   task automatic t_turn();
      int b_bta, b_esc;
      restart();
      b_bta = k_bta; b_esc = k_esc;
      drive(2'b10); drive(2'b00); drive(2'b10); drive(2'b00);
      check("R6 turn pulse", k_bta - b_bta, 1);
      check("R6 turn mode", d_mode, 4);
      check("R6 no esc", k_esc - b_esc, 0);
      drive(2'b11);
      check("R6 turn exit", d_mode, 1);
   endtask

   task automatic t_error();
      int b_hs, b_err;
      restart();
      b_hs = k_hs; b_err = k_derr;
      drive(2'b10); drive(2'b01);
      check("R7 error pulse", k_derr - b_err, 1);
      drive(2'b00); drive(2'b01); drive(2'b00);
      check("R7 no request before idle", k_hs - b_hs, 0);
      check("R7 mode while waiting", d_mode, 1);
      drive(2'b11); drive(2'b01); drive(2'b00);
      check("R7 recovers after idle", k_hs - b_hs, 1);
      check("R7 single error", k_derr - b_err, 1);
   endtask

   task automatic t_ulp();
      int b_culp, b_cerr, b_dulp;
      restart();
      b_culp = k_culp; b_cerr = k_cerr; b_dulp = k_dulp;
      drive(2'b10); drive(2'b00);
      check("R9 ulp pulse", k_culp - b_culp, 1);
      check("R9 ulp mode", c_mode, 5);
      check("R9 data lane no ulp", k_dulp - b_dulp, 0);
      drive(2'b10, 2 * WAKE_CYC); drive(2'b11);
      check("R10 wake ok mode", c_mode, 1);
      check("R10 wake ok no error", k_cerr - b_cerr, 0);
      drive(2'b10); drive(2'b00);
      drive(2'b10, WAKE_CYC / 4); drive(2'b11);
      check("R10 early wake error", k_cerr - b_cerr, 1);
      check("R10 early wake mode", c_mode, 1);
   endtask

   initial begin
      t_reset();
      t_hs();
      t_glitch();
      t_esc();
      t_turn();
      t_error();
      t_ulp();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule